// File: doc/BRIEF.md
# Active Destination Queue Allocator

This block binds destination tags to a small pool of staging queues. Each incoming frame presents its destination tag. The block answers with the id of the staging queue that collects frames for that destination. A destination that already owns a queue gets the same id back. A destination that owns none gets a free id from a pool. In the same cycle that the table is looked up, the block takes the head of the free pool speculatively. If the destination turns out to be owned already, that id goes back to the pool, so an answer never needs a second lookup.

A reverse map records which destination each queue serves. When a staging queue reports that it has fully drained downstream, the block finds that destination through the reverse map, marks the destination as unowned, and appends the queue id to the tail of the free pool. The staging storage itself and the burst writer sit outside this block.

Top module: `dest_queue_alloc`

## Requirements
- R1: After a synchronous reset, `res_valid` and `stall` are low, every destination is unowned, and the free pool holds ids 0 to NQ-1 with id 0 at its head, so successive new destinations receive ids 0, 1, 2, 3.
- R2: A lookup is accepted in a cycle where `lk_valid` is high and `stall` is low. In the next cycle `res_valid` is high for exactly one cycle.
- R3: A lookup of an unowned destination receives the id at the head of the free pool, with `res_new` = 1. From then on the destination owns that id.
- R4: A lookup of an owned destination returns its id with `res_new` = 0. The id taken speculatively from the head of the pool is appended to the pool's tail, so the pool order rotates by one. This is also served when the pool is empty.
- R5: A lookup of the same new destination in the cycle right after its assignment is a hit on the just-assigned id.
- R6: `stall` is high exactly when a presented lookup targets an unowned destination and no id is available. While it is high, no lookup is accepted and no result appears.
- R7: A release pulse (`rel_valid` with `rel_qid`) makes the destination served by that queue unowned, and appends the id to the tail of the free pool. Other destinations keep their ids.
- R8: A release and a lookup in the same cycle are handled release first. The released id joins the pool before the lookup takes from it. A lookup of the destination being released is therefore a miss.
- R9: A stalled lookup is accepted in the cycle that a release occurs, and it receives the released id when the pool was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_tag | input | TAG_W | Destination tag of the lookup |
| rel_valid | input | 1 | A staging queue has fully drained |
| rel_qid | input | QW | Id of the drained queue |
| stall | output | 1 | Lookup cannot be accepted this cycle |
| res_valid | output | 1 | Result of the lookup accepted last cycle |
| res_qid | output | QW | Queue id assigned to the destination |
| res_new | output | 1 | 1 when the id was newly assigned |

## Verification
The bench checks that a hit rotates the free pool. A design that dropped the returned id would stall on a later new destination, and one that put it back at the head would hand out ids in the wrong order. It issues lookups back to back for one new tag. A table without a bypass for the entry still being written would assign that destination a second queue. It releases and looks up the same tag in one cycle, both with an empty pool and with a non-empty one. A design that handled the lookup before the release would report a hit on a stale id. It also releases while a lookup is stalled. A design that ignored the release in that cycle would hold the stall one cycle too long, or hand out an id other than the one just released.

// File: rtl/dqa_pkg.sv
package dqa_pkg;
  // next index in a ring of lim entries
  function automatic int unsigned ring_next(input int unsigned x, input int unsigned lim);
    return (x + 1 >= lim) ? 0 : x + 1;
  endfunction
endpackage

// File: rtl/dqa_free_pool.sv
module dqa_free_pool #(
  parameter int NQ = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW = $clog2(NQ + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel_push,
  input  logic [QW-1:0] rel_id,
  input  logic          pop,
  input  logic          back_push,
  input  logic [QW-1:0] back_id,
  output logic [QW-1:0] head,
  output logic          avail,
  output logic [CW-1:0] cnt
);
  import dqa_pkg::*;

  logic [QW-1:0] ids [NQ];
  logic [QW-1:0] rd, wr, wr_mid, wr_end;

  // a release id is usable by the same cycle's pop (release first)
  assign avail = (cnt != '0) || rel_push;
  assign head  = (cnt == '0) ? rel_id : ids[rd];

  always_comb begin
    wr_mid = rel_push  ? QW'(ring_next(int'(wr), NQ))     : wr;
    wr_end = back_push ? QW'(ring_next(int'(wr_mid), NQ)) : wr_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) ids[i] <= QW'(i);
      rd  <= '0;
      wr  <= '0;
      cnt <= CW'(NQ);
    end else begin
      if (rel_push)  ids[wr]     <= rel_id;
      if (back_push) ids[wr_mid] <= back_id;
      if (pop) rd <= QW'(ring_next(int'(rd), NQ));
      wr  <= wr_end;
      cnt <= cnt + CW'(rel_push) + CW'(back_push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) a_r7_pool_bound: assert (cnt <= CW'(NQ)) else $error("free pool count above NQ");
  end

  a_r1_pool_full_after_reset: assert property (@(posedge clk) rst |=> (cnt == CW'(NQ)));
endmodule

// File: rtl/dqa_dest_table.sv
module dqa_dest_table #(
  parameter int TAG_W = 6,
  parameter int NQ    = 4,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int TAGS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [QW-1:0]    set_qid,
  output logic             hit,
  output logic [QW-1:0]    hit_qid
);
  logic [QW-1:0]    qid_mem [TAGS];
  logic [TAGS-1:0]  owned;
  logic             pend_v;
  logic [TAG_W-1:0] pend_tag;
  logic [QW-1:0]    pend_qid;
  logic             pend_commit;

  // a release of the pending tag cancels the deferred write
  assign pend_commit = pend_v && !(clr_en && clr_tag == pend_tag);

  always_comb begin
    if (clr_en && clr_tag == lk_tag) begin
      hit = 1'b0;  hit_qid = pend_qid;
    end else if (pend_v && pend_tag == lk_tag) begin
      hit = 1'b1;  hit_qid = pend_qid;
    end else begin
      hit = owned[lk_tag];  hit_qid = qid_mem[lk_tag];
    end
  end

  always_ff @(posedge clk) begin
    if (pend_commit) qid_mem[pend_tag] <= pend_qid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owned    <= '0;
      pend_v   <= 1'b0;
      pend_tag <= '0;
      pend_qid <= '0;
    end else begin
      if (pend_commit) owned[pend_tag] <= 1'b1;
      if (clr_en)      owned[clr_tag]  <= 1'b0;
      pend_v   <= set_en;
      pend_tag <= set_tag;
      pend_qid <= set_qid;
    end
  end

  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_tag == clr_tag)) |=> !owned[$past(clr_tag)]);
endmodule

// File: rtl/dqa_owner_map.sv
module dqa_owner_map #(
  parameter int TAG_W = 6,
  parameter int NQ    = 4,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_qid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [QW-1:0]    rd_qid,
  output logic [TAG_W-1:0] rd_tag
);
  logic [TAG_W-1:0] owner [NQ];

  always_ff @(posedge clk) begin
    if (wr_en) owner[wr_qid] <= wr_tag;
  end

  assign rd_tag = owner[rd_qid];
endmodule

// File: rtl/dest_queue_alloc.sv
module dest_queue_alloc #(
  parameter int TAG_W = 6,
  parameter int NQ    = 4,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW   = $clog2(NQ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             rel_valid,
  input  logic [QW-1:0]    rel_qid,
  output logic             stall,
  output logic             res_valid,
  output logic [QW-1:0]    res_qid,
  output logic             res_new
);
  logic             hit, avail, accept, assign_new, give_back;
  logic [QW-1:0]    hit_qid, head;
  logic [TAG_W-1:0] rel_tag;
  logic [CW-1:0]    free_cnt;

  assign stall      = lk_valid && !hit && !avail;
  assign accept     = lk_valid && !stall;
  assign assign_new = accept && !hit;
  assign give_back  = accept && hit && avail;

  dqa_owner_map #(.TAG_W(TAG_W), .NQ(NQ)) u_owner (
    .clk(clk), .wr_en(assign_new), .wr_qid(head), .wr_tag(lk_tag),
    .rd_qid(rel_qid), .rd_tag(rel_tag));

  dqa_dest_table #(.TAG_W(TAG_W), .NQ(NQ)) u_table (
    .clk(clk), .rst(rst), .lk_tag(lk_tag),
    .clr_en(rel_valid), .clr_tag(rel_tag),
    .set_en(assign_new), .set_tag(lk_tag), .set_qid(head),
    .hit(hit), .hit_qid(hit_qid));

  dqa_free_pool #(.NQ(NQ)) u_pool (
    .clk(clk), .rst(rst), .rel_push(rel_valid), .rel_id(rel_qid),
    .pop(accept && avail), .back_push(give_back), .back_id(head),
    .head(head), .avail(avail), .cnt(free_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_qid   <= '0;
      res_new   <= 1'b0;
    end else begin
      res_valid <= accept;
      res_qid   <= hit ? hit_qid : head;
      res_new   <= !hit;
    end
  end

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !stall) |=> res_valid);
  a_r6_stall_no_result: assert property (@(posedge clk) disable iff (rst)
    stall |=> !res_valid);
  a_r6_stall_pool_empty: assert property (@(posedge clk) disable iff (rst)
    stall |-> (free_cnt == '0 && !rel_valid));
  a_r4_hit_keeps_pool: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hit && !rel_valid) |=> (free_cnt == $past(free_cnt)));
endmodule

// File: tb/sim_dest_queue_alloc.sv
module sim_dest_queue_alloc;
  logic       clk = 1'b0;
  logic       rst;
  logic       lk_valid, rel_valid;
  logic [5:0] lk_tag;
  logic [1:0] rel_qid;
  logic       stall, res_valid, res_new;
  logic [1:0] res_qid;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dest_queue_alloc #(.TAG_W(6), .NQ(4)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rel_valid(rel_valid), .rel_qid(rel_qid), .stall(stall),
    .res_valid(res_valid), .res_qid(res_qid), .res_new(res_new));

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // presents one lookup; checks the result one cycle after acceptance
  task automatic lookup(input int tag, input int eq, input int en, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = 6'(tag);
    #1 check(req, int'(stall), 0, "stall on lookup");
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, int'(res_valid), 1, "res_valid");
    check(req, int'(res_qid), eq, "res_qid");
    check(req, int'(res_new), en, "res_new");
  endtask

  task automatic release_q(input int q);
    @(negedge clk);
    rel_valid = 1'b1; rel_qid = 2'(q);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", int'(res_valid), 0, "res_valid after reset");
    check("R1", int'(stall), 0, "stall after reset");
    lookup(10, 0, 1, "R1");
    lookup(11, 1, 1, "R3");
    lookup(12, 2, 1, "R3");
    lookup(13, 3, 1, "R1");
    @(negedge clk);
    check("R2", int'(res_valid), 0, "res_valid one cycle only");
  endtask

  task automatic t_hit_empty;
    lookup(11, 1, 0, "R4");   // pool empty, hit still served
  endtask

  task automatic t_stall_release;
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = 6'd20;
    #1 check("R6", int'(stall), 1, "stall on miss with empty pool");
    @(negedge clk);
    check("R6", int'(res_valid), 0, "no result while stalled");
    check("R6", int'(stall), 1, "stall held");
    rel_valid = 1'b1; rel_qid = 2'd2;   // tag 12 drains
    #1 check("R9", int'(stall), 0, "stall clears with release");
    @(negedge clk);
    lk_valid = 1'b0; rel_valid = 1'b0;
    check("R9", int'(res_valid), 1, "stalled lookup accepted");
    check("R9", int'(res_qid), 2, "gets released id");
    check("R9", int'(res_new), 1, "new assignment");
  endtask

  task automatic t_rotation;
    release_q(0);             // pool [0]
    release_q(1);             // pool [0,1]
    lookup(13, 3, 0, "R4");   // pool [1,0]
    lookup(30, 1, 1, "R4");
    lookup(31, 0, 1, "R4");
  endtask

  task automatic t_release_other;
    release_q(2);             // tag 20 drains
    lookup(13, 3, 0, "R7");
    lookup(20, 2, 1, "R7");
  endtask

  task automatic t_same_cycle(input int q, input int tag, input int eq, input string req);
    @(negedge clk);
    rel_valid = 1'b1; rel_qid = 2'(q);
    lk_valid = 1'b1; lk_tag = 6'(tag);
    #1 check(req, int'(stall), 0, "no stall with release");
    @(negedge clk);
    rel_valid = 1'b0; lk_valid = 1'b0;
    check(req, int'(res_valid), 1, "res_valid");
    check(req, int'(res_qid), eq, "res_qid");
    check(req, int'(res_new), 1, "release first makes a miss");
  endtask

  task automatic t_back_to_back;
    release_q(1);             // tag 30, pool [1]
    release_q(0);             // tag 31, pool [1,0]
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = 6'd40;
    @(negedge clk);
    check("R5", int'(res_qid), 1, "first assignment id");
    check("R5", int'(res_new), 1, "first is new");
    @(negedge clk);
    lk_valid = 1'b0;
    check("R5", int'(res_valid), 1, "second result");
    check("R5", int'(res_qid), 1, "second hits same id");
    check("R5", int'(res_new), 0, "second is a hit");
    lookup(40, 1, 0, "R5");
  endtask

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_tag = '0; rel_valid = 1'b0; rel_qid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hit_empty();
    t_stall_release();
    t_rotation();
    t_release_other();
    t_same_cycle(3, 13, 3, "R8");   // empty pool: takes the released id
    t_back_to_back();               // pool now [0]
    t_same_cycle(2, 20, 0, "R8");   // pool [0,2]: head 0 goes to tag 20
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule